// File: doc/BRIEF.md
# Machine-Cycle Sequencer with Refresh Counter

This block tracks the machine-cycle timing of an 8-bit processor while it fetches and executes one instruction. A start pulse and an instruction-class code are taken in while the block is idle. The block then steps through the machine cycles (M-cycles) of that class, one clock per T-state. For every step it reports the cycle kind, the current T-state number and the step index.

Every opcode-fetch cycle, including each prefix fetch, drives a refresh strobe during its third and fourth T-states. While the strobe is high, the refresh address carries the refresh register. At the end of the fourth T-state the low seven bits of that register count up and wrap, and the top bit keeps its value. A load input can write all eight bits at any time.

The indexed bit-rotate class reads its displacement byte with an ordinary memory read. Its opcode fetch therefore comes after a non-fetch cycle. The block-repeat class runs its fetch sequence again on each repetition, so each pass adds refresh counts.

Top module: `ftc_cycle_tracker`

## Requirements
- R1: After reset the block is idle: `kind_o` is 0, `tstate_o` is 0, `busy_o`, `done_o` and `rfsh_o` are low, and the refresh register reads 0x00.
- R2: Class 0 (plain) runs one fetch cycle of 4 T-states and gives one refresh.
- R3: Class 1 (prefixed) runs two fetch cycles of 4 T-states each, 8 T-states in total, with two refreshes.
- R4: Class 2 (indexed bit) runs these steps in order: fetch 4, fetch 4, read 3, fetch 5, read 4, write 3. That is 23 T-states and three refreshes. The displacement read (step 2) never raises the strobe.
- R5: `rfsh_o` is high exactly in T-states 3 and 4 of fetch cycles. `rfsh_addr_o` equals the refresh register while `rfsh_o` is high and 0 otherwise.
- R6: At the clock edge that ends T-state 4 of a fetch cycle, bits 6:0 of the refresh register add one and wrap from 0x7F to 0x00. Bit 7 is unchanged.
- R7: Class 3 (block repeat) with repetition count N runs N+1 passes. Each pass is fetch 4, fetch 4, read 3, write 5. An internal cycle of 5 T-states lies between passes. Total: 16(N+1)+5N T-states and 2(N+1) refreshes.
- R8: `ld_i` writes `ld_val_i` into all 8 bits of the refresh register at the next edge. It takes priority over a counting step at the same edge.
- R9: `start_i` has no effect while `busy_o` is high. The running instruction keeps its class and timing.
- R10: `kind_o` codes the cycle kind as idle 0, fetch 1, read 2, write 3, internal 4. `tstate_o` counts 1 up to the step length. `done_o` is high in the final T-state of the instruction only. A start taken at an edge shows T-state 1 of step 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an instruction when idle |
| cls_i | input | 2 | Instruction class: 0 plain, 1 prefixed, 2 indexed bit, 3 block repeat |
| rep_i | input | REP_W | Repetition count for class 3 |
| ld_i | input | 1 | Load refresh register |
| ld_val_i | input | 8 | Value to load |
| busy_o | output | 1 | Instruction in progress |
| kind_o | output | 3 | Current M-cycle kind |
| tstate_o | output | 3 | Current T-state number within the step |
| step_o | output | 3 | Step index within the pass |
| done_o | output | 1 | Last T-state of the instruction |
| rfsh_o | output | 1 | Refresh strobe |
| rfsh_addr_o | output | 8 | Refresh address while the strobe is high |
| r_o | output | 8 | Refresh register value |

## Verification
The bench runs every class. For block repeat it uses repetition counts 0 to 3, which separates a single pass from the passes joined by the internal cycle. Every T-state is compared with an independent cycle model. Per-instruction totals of T-states and refresh pulses are also compared with closed-form counts, which catches a miscounted step or a fetch that wrongly refreshes, such as the displacement read. Loads at 0x7E and 0xFE test the 7-bit wrap with bit 7 both clear and set. A load placed on the counting edge, and start pulses held high during a busy instruction, test the load priority and the start-ignore rule.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    localparam int RFSH_W    = 8;
    localparam int STEP_W    = 3;
    localparam int T_W       = 3;
    localparam int RFSH_T_LO = 3;
    localparam int RFSH_T_HI = 4;
    localparam int REPASS_IX = 4;

    typedef enum logic [2:0] {
        MC_IDLE     = 3'd0,
        MC_FETCH    = 3'd1,
        MC_READ     = 3'd2,
        MC_WRITE    = 3'd3,
        MC_INTERNAL = 3'd4
    } mcyc_e;

    typedef enum logic [1:0] {
        CL_PLAIN  = 2'd0,
        CL_PREFIX = 2'd1,
        CL_IDXBIT = 2'd2,
        CL_BLOCK  = 2'd3
    } icls_e;

    typedef struct packed {
        mcyc_e            kind;
        logic [T_W-1:0]   len;
        logic             last;
    } mstep_t;

    function automatic mstep_t mk(mcyc_e k, int unsigned n, logic l);
        mstep_t s;
        s.kind = k;
        s.len  = T_W'(n);
        s.last = l;
        return s;
    endfunction

    // Step table: cycle kind, length in T-states, and end-of-pass flag.
    function automatic mstep_t step_of(icls_e c, logic [STEP_W-1:0] ix);
        mstep_t s;
        s = mk(MC_IDLE, 1, 1'b1);
        unique case (c)
            CL_PLAIN: begin
                if (ix == 0) s = mk(MC_FETCH, 4, 1'b1);
            end
            CL_PREFIX: begin
                case (ix)
                    3'd0: s = mk(MC_FETCH, 4, 1'b0);
                    3'd1: s = mk(MC_FETCH, 4, 1'b1);
                    default: s = mk(MC_IDLE, 1, 1'b1);
                endcase
            end
            CL_IDXBIT: begin
                case (ix)
                    3'd0: s = mk(MC_FETCH, 4, 1'b0);
                    3'd1: s = mk(MC_FETCH, 4, 1'b0);
                    3'd2: s = mk(MC_READ,  3, 1'b0);
                    3'd3: s = mk(MC_FETCH, 5, 1'b0);
                    3'd4: s = mk(MC_READ,  4, 1'b0);
                    3'd5: s = mk(MC_WRITE, 3, 1'b1);
                    default: s = mk(MC_IDLE, 1, 1'b1);
                endcase
            end
            CL_BLOCK: begin
                case (ix)
                    3'd0: s = mk(MC_FETCH,    4, 1'b0);
                    3'd1: s = mk(MC_FETCH,    4, 1'b0);
                    3'd2: s = mk(MC_READ,     3, 1'b0);
                    3'd3: s = mk(MC_WRITE,    5, 1'b1);
                    3'd4: s = mk(MC_INTERNAL, 5, 1'b0);
                    default: s = mk(MC_IDLE, 1, 1'b1);
                endcase
            end
            default: s = mk(MC_IDLE, 1, 1'b1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ftc_rfsh_reg.sv
module ftc_rfsh_reg
    import ftc_pkg::*;
#(
    parameter int W = RFSH_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         bump,
    output logic [W-1:0] r
);
    localparam int LOW_W = W - 1;

    always_ff @(posedge clk) begin
        if (rst)       r <= '0;
        else if (ld)   r <= ld_val;
        else if (bump) r <= {r[W-1], r[LOW_W-1:0] + LOW_W'(1)};
    end

    assert_bit7_held_R6: assert property (@(posedge clk) disable iff (rst)
        (bump && !ld) |=> (r[W-1] == $past(r[W-1])) &&
                          (r[LOW_W-1:0] == $past(r[LOW_W-1:0]) + LOW_W'(1)));

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
        ld |=> r == $past(ld_val));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!ld && !bump) |=> $stable(r));
endmodule

// File: rtl/ftc_seq.sv
module ftc_seq
    import ftc_pkg::*;
#(
    parameter int REP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  icls_e             cls,
    input  logic [REP_W-1:0]  rep,
    output logic              busy,
    output mcyc_e             kind,
    output logic [T_W-1:0]    tstate,
    output logic [STEP_W-1:0] step,
    output logic              done
);
    logic              busy_q;
    icls_e             cls_q;
    logic [STEP_W-1:0] ix_q;
    logic [T_W-1:0]    t_q;
    logic [REP_W-1:0]  rep_q;
    mstep_t            cur;
    logic              step_end;
    logic              more_pass;
    logic              instr_end;

    always_comb begin
        cur       = step_of(cls_q, ix_q);
        step_end  = busy_q && (t_q == cur.len);
        more_pass = (cls_q == CL_BLOCK) && (rep_q != '0);
        instr_end = step_end && cur.last && !more_pass;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cls_q  <= CL_PLAIN;
            ix_q   <= '0;
            t_q    <= '0;
            rep_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cls_q  <= cls;
                ix_q   <= '0;
                t_q    <= T_W'(1);
                rep_q  <= rep;
            end
        end else if (step_end) begin
            t_q <= T_W'(1);
            if (instr_end) begin
                busy_q <= 1'b0;
                ix_q   <= '0;
                t_q    <= '0;
            end else if (cur.last) begin
                ix_q <= STEP_W'(REPASS_IX);
            end else if (cls_q == CL_BLOCK && ix_q == STEP_W'(REPASS_IX)) begin
                ix_q  <= '0;
                rep_q <= rep_q - REP_W'(1);
            end else begin
                ix_q <= ix_q + STEP_W'(1);
            end
        end else begin
            t_q <= t_q + T_W'(1);
        end
    end

    assign busy   = busy_q;
    assign kind   = busy_q ? cur.kind : MC_IDLE;
    assign tstate = t_q;
    assign step   = ix_q;
    assign done   = instr_end;

    assert_tstate_range_R10: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (t_q >= T_W'(1)) && (t_q <= T_W'(5)));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !instr_end) |=> (cls_q == $past(cls_q)) && busy_q);

    assert_tstep_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !step_end) |=> (t_q == $past(t_q) + T_W'(1)));

    assert_fetch_len_R2: assert property (@(posedge clk) disable iff (rst)
        (kind == MC_FETCH && step_end) |-> t_q >= T_W'(4));
endmodule

// File: rtl/ftc_cycle_tracker.sv
module ftc_cycle_tracker
    import ftc_pkg::*;
#(
    parameter int REP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        cls_i,
    input  logic [REP_W-1:0]  rep_i,
    input  logic              ld_i,
    input  logic [7:0]        ld_val_i,
    output logic              busy_o,
    output logic [2:0]        kind_o,
    output logic [2:0]        tstate_o,
    output logic [2:0]        step_o,
    output logic              done_o,
    output logic              rfsh_o,
    output logic [7:0]        rfsh_addr_o,
    output logic [7:0]        r_o
);
    mcyc_e          kind;
    logic [T_W-1:0] tst;
    logic           bump;
    logic [7:0]     r;

    ftc_seq #(.REP_W(REP_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .cls    (icls_e'(cls_i)),
        .rep    (rep_i),
        .busy   (busy_o),
        .kind   (kind),
        .tstate (tst),
        .step   (step_o),
        .done   (done_o)
    );

    always_comb begin
        rfsh_o = (kind == MC_FETCH) &&
                 (tst == T_W'(RFSH_T_LO) || tst == T_W'(RFSH_T_HI));
        bump   = (kind == MC_FETCH) && (tst == T_W'(RFSH_T_HI));
    end

    ftc_rfsh_reg #(.W(8)) u_rreg (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld_i),
        .ld_val (ld_val_i),
        .bump   (bump),
        .r      (r)
    );

    assign kind_o      = kind;
    assign tstate_o    = tst;
    assign r_o         = r;
    assign rfsh_addr_o = rfsh_o ? r : 8'h00;

    assert_rfsh_fetch_only_R5: assert property (@(posedge clk) disable iff (rst)
        rfsh_o |-> kind == MC_FETCH);

    assert_disp_no_rfsh_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cls_i == 2'd2 && step_o == 3'd2 && kind == MC_READ) |-> !rfsh_o);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!rfsh_o && !done_o));
endmodule

// File: tb/sim_ftc_cycle_tracker.sv
module sim_ftc_cycle_tracker;
    localparam int PERIOD = 10;
    localparam int REP_W  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [1:0]       cls_i = 2'd0;
    logic [REP_W-1:0] rep_i = '0;
    logic             ld_i = 1'b0;
    logic [7:0]       ld_val_i = 8'h00;
    logic             busy_o, done_o, rfsh_o;
    logic [2:0]       kind_o, tstate_o, step_o;
    logic [7:0]       rfsh_addr_o, r_o;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    bit       m_busy = 0;
    int       m_cls = 0, m_ix = 0, m_t = 0, m_rep = 0;
    logic [7:0] m_r = 8'h00;

    always #(PERIOD/2) clk = ~clk;

    ftc_cycle_tracker #(.REP_W(REP_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .cls_i(cls_i), .rep_i(rep_i),
        .ld_i(ld_i), .ld_val_i(ld_val_i), .busy_o(busy_o), .kind_o(kind_o),
        .tstate_o(tstate_o), .step_o(step_o), .done_o(done_o), .rfsh_o(rfsh_o),
        .rfsh_addr_o(rfsh_addr_o), .r_o(r_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // Step table from the requirements: kind code, length, end-of-pass.
    function automatic void tbl(input int c, input int ix, output int k, output int n, output bit e);
        k = 0; n = 1; e = 1;
        if (c == 0 && ix == 0) begin k = 1; n = 4; end
        else if (c == 1) begin k = 1; n = 4; e = (ix == 1); end
        else if (c == 2) begin
            int ks[6] = '{1, 1, 2, 1, 2, 3};
            int ns[6] = '{4, 4, 3, 5, 4, 3};
            if (ix < 6) begin k = ks[ix]; n = ns[ix]; e = (ix == 5); end
        end else if (c == 3) begin
            int ks[5] = '{1, 1, 2, 3, 4};
            int ns[5] = '{4, 4, 3, 5, 5};
            if (ix < 5) begin k = ks[ix]; n = ns[ix]; e = (ix == 3); end
        end
    endfunction

    task automatic compare();
        int k, n; bit e; int ek; bit erf, edone;
        tbl(m_cls, m_ix, k, n, e);
        ek    = m_busy ? k : 0;
        erf   = m_busy && k == 1 && (m_t == 3 || m_t == 4);
        edone = m_busy && m_t == n && e && !(m_cls == 3 && m_rep != 0);
        chk("R10 kind", int'(kind_o), ek);
        chk("R10 tstate", int'(tstate_o), m_busy ? m_t : 0);
        chk("R10 done", int'(done_o), int'(edone));
        chk("R5 strobe", int'(rfsh_o), int'(erf));
        chk("R5 address", int'(rfsh_addr_o), erf ? int'(m_r) : 0);
        chk("R6 register", int'(r_o), int'(m_r));
    endtask

    // Drive one cycle, advance the model across the edge, compare after it.
    task automatic cyc(input bit s, input int c, input int rp, input bit l, input logic [7:0] lv);
        int k, n; bit e;
        start_i = s; cls_i = 2'(c); rep_i = REP_W'(rp); ld_i = l; ld_val_i = lv;
        tbl(m_cls, m_ix, k, n, e);
        if (l) m_r = lv;
        else if (m_busy && k == 1 && m_t == 4) m_r = {m_r[7], 7'(m_r[6:0] + 7'd1)};
        if (!m_busy) begin
            if (s) begin m_busy = 1; m_cls = c; m_ix = 0; m_t = 1; m_rep = rp; end
        end else if (m_t == n) begin
            m_t = 1;
            if (e && !(m_cls == 3 && m_rep != 0)) begin m_busy = 0; m_ix = 0; m_t = 0; end
            else if (e) m_ix = 4;
            else if (m_cls == 3 && m_ix == 4) begin m_ix = 0; m_rep--; end
            else m_ix++;
        end else m_t++;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int c, input int rp, input int ld_at, input logic [7:0] lv, input bit poke);
        int tsum = 0, rcnt = 0, k = 0, fetches, tot;
        logic [7:0] r0;
        string tag;
        r0 = m_r;
        cyc(1, c, rp, 0, 8'h00);
        while (m_busy && k < 400) begin
            if (busy_o) tsum++;
            if (rfsh_o) rcnt++;
            cyc(poke, (c + 1) % 4, 0, k == ld_at, lv);
            k++;
        end
        cyc(0, 0, 0, 0, 8'h00);
        case (c)
            0: begin tag = "R2"; fetches = 1; tot = 4; end
            1: begin tag = "R3"; fetches = 2; tot = 8; end
            2: begin tag = "R4"; fetches = 3; tot = 23; end
            default: begin tag = "R7"; fetches = 2 * (rp + 1); tot = 16 * (rp + 1) + 5 * rp; end
        endcase
        if (poke) tag = {tag, " R9"};
        chk({tag, " T-state total"}, tsum, tot);
        chk({tag, " refresh cycles"}, rcnt, 2 * fetches);
        if (ld_at < 0)
            chk("R6 count per instruction", int'(r_o),
                int'({r0[7], 7'(r0[6:0] + 7'(fetches))}));
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 kind", int'(kind_o), 0);
        chk("R1 strobe", int'(rfsh_o), 0);
        chk("R1 register", int'(r_o), 0);
        compare();
        // sweep every class; block repeat over several counts
        for (int c = 0; c < 3; c++) run(c, 0, -1, 8'h00, 0);
        for (int rp = 0; rp < 4; rp++) run(3, rp, -1, 8'h00, 0);
        // R9 start held high while busy
        run(2, 0, -1, 8'h00, 1);
        run(3, 2, -1, 8'h00, 1);
        // R6 wrap with bit 7 clear
        cyc(0, 0, 0, 1, 8'h7E);
        chk("R8 load idle", int'(r_o), 8'h7E);
        run(0, 0, -1, 8'h00, 0);
        run(0, 0, -1, 8'h00, 0);
        chk("R6 wrap bit7 clear", int'(r_o), 8'h00);
        // R6 wrap with bit 7 set
        cyc(0, 0, 0, 1, 8'hFE);
        run(1, 0, -1, 8'h00, 0);
        chk("R6 wrap bit7 set", int'(r_o), 8'h80);
        run(2, 0, -1, 8'h00, 0);
        chk("R6 bit7 held", int'(r_o), 8'h83);
        // R8 load on the counting edge of a plain fetch
        run(0, 0, 3, 8'h55, 0);
        chk("R8 load beats count", int'(r_o), 8'h55);
        // R8 load mid indexed instruction (during displacement read)
        run(2, 0, 9, 8'hC0, 0);
        chk("R8 load mid instruction", int'(r_o), 8'hC1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule